// File: doc/BRIEF.md
# Peripheral and Memory Security Gate

This block sits between bus initiators and a set of up to 32 peripherals plus one memory. Each peripheral has two protection attributes held in configuration: a secure bit and a privileged bit. The memory is split by a single watermark address into a secure lower part and a non-secure upper part. Every peripheral or memory access arrives with its own secure and privileged attributes. The gate compares them with the configuration and either passes the access or blocks it. A blocked read returns zero and a blocked write is dropped.

Blocked accesses set sticky event flags, one per peripheral and one for the memory. Each flag has its own enable bit, and the enabled, set flags are ORed into a single interrupt. A small register port carries the configuration. The world and privilege of each configuration write decide whether it is accepted. A one-way lock freezes the protection settings until reset. A global security-enable input switches off all memory security and the interrupt. Peripheral privilege checks stay in force when that input is low.

Top module: `sec_gate`

## Requirements
- R1: After reset, all configuration words read 0: lock, peripheral secure bits, peripheral privileged bits, watermark, enables and flags. `irq` is 0.
- R2: Configuration address map: 0 lock (bit 0, write 1 to set), 1 peripheral secure bits, 2 peripheral privileged bits, 3 watermark (bits 12:0), 4 peripheral event enables, 5 peripheral event flags (write 1 to clear), 6 memory event enable (bit 0), 7 memory event flag (bit 0, write 1 to clear). Bit n of words 1, 2, 4 and 5 belongs to peripheral n. A write to any word except 3 takes effect only when `cfg_secure` and `cfg_priv` are both 1. Otherwise it leaves every word unchanged.
- R3: While unlocked, a secure privileged write may set the watermark to any value. A non-secure privileged write is accepted only if its value is greater than or equal to the current watermark, so it can shrink the non-secure area but never enlarge it. An unprivileged write is ignored.
- R4: Once the lock bit is set, writes to words 1, 2 and 3 are ignored until reset. The lock bit itself cannot be cleared. The event enable and flag words stay writable.
- R5: With `sec_en`=1, an access to a peripheral whose secure bit is 1 is blocked when `p_secure`=0.
- R6: An access with `p_priv`=0 to a peripheral whose privileged bit is 1 is blocked, whatever the value of `sec_en`. With `sec_en`=0, the secure bits block nothing.
- R7: `p_allow` follows the result of the check, in the same cycle. A blocked read gives `p_rdata`=0 and a blocked write gives `p_wr_out`=0. An allowed read passes `p_rdata_in` through, and an allowed write raises `p_wr_out`.
- R8: With `sec_en`=1, a memory access with `m_secure`=0 and an address strictly below the watermark is blocked. Addresses at or above the watermark are allowed, and so are secure accesses. With `sec_en`=0, every memory access is allowed.
- R9: A blocked access while `sec_en`=1 sets the flag of its source on the next clock edge. A blocked peripheral access sets bit `p_target` of word 5, and a blocked memory access sets bit 0 of word 7. The flag stays set until it is cleared by writing 1. If a set and a clear of the same flag fall in the same cycle, the set wins. No flag is set while `sec_en`=0.
- R10: `irq` is 1 exactly when `sec_en`=1 and some flag is set with its enable also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_en | input | 1 | Global security enable |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_secure | input | 1 | Secure attribute of the configuration write |
| cfg_priv | input | 1 | Privileged attribute of the configuration write |
| cfg_rdata | output | 32 | Read data of the addressed configuration word (combinational) |
| p_valid | input | 1 | Peripheral access valid |
| p_target | input | 5 | Peripheral index |
| p_secure | input | 1 | Secure attribute of the peripheral access |
| p_priv | input | 1 | Privileged attribute of the peripheral access |
| p_write | input | 1 | 1 = write, 0 = read |
| p_rdata_in | input | 32 | Read data returned by the target peripheral |
| p_allow | output | 1 | Access passes the check |
| p_wr_out | output | 1 | Write strobe forwarded to the peripheral |
| p_rdata | output | 32 | Read data returned to the initiator |
| m_valid | input | 1 | Memory access valid |
| m_addr | input | 12 | Memory word address |
| m_secure | input | 1 | Secure attribute of the memory access |
| m_allow | output | 1 | Memory access passes the check |
| irq | output | 1 | Combined illegal-access interrupt |

## Verification
The peripheral check is swept over all 32 targets and all four secure/privileged attribute pairs, once with security enabled and once with it disabled. The mask pattern sets each of the four secure/privileged bit pairs on some targets, so a secure check that is lost, a privilege check that is gated by `sec_en`, or a polarity swap each give a different set of targets that fail. The memory check is tried one below, at and one above the watermark. This separates a strict comparison from a non-strict one. Configuration writes are tried with every world/privilege pair, both before and after locking, and the watermark is also written with values above and below its current value.

// File: rtl/sec_gate.sv
module sec_gate #(
  parameter int NPERIPH = 32,
  parameter int MAW     = 12,
  localparam int TW     = (NPERIPH > 1) ? $clog2(NPERIPH) : 1,
  localparam int WMW    = MAW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sec_en,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [31:0]   cfg_wdata,
  input  logic          cfg_secure,
  input  logic          cfg_priv,
  output logic [31:0]   cfg_rdata,
  input  logic          p_valid,
  input  logic [TW-1:0] p_target,
  input  logic          p_secure,
  input  logic          p_priv,
  input  logic          p_write,
  input  logic [31:0]   p_rdata_in,
  output logic          p_allow,
  output logic          p_wr_out,
  output logic [31:0]   p_rdata,
  input  logic          m_valid,
  input  logic [MAW-1:0] m_addr,
  input  logic          m_secure,
  output logic          m_allow,
  output logic          irq
);

  logic               lock_q;
  logic [NPERIPH-1:0] psec_q, ppriv_q, pie_q, pflag_q;
  logic [WMW-1:0]     wm_q;
  logic               mie_q, mflag_q;

  wire trusted  = cfg_secure & cfg_priv;
  wire wr_trust = cfg_we & trusted;
  wire [WMW-1:0] wm_new = cfg_wdata[WMW-1:0];
  wire wm_ok = cfg_we && cfg_addr == 3'd3 && !lock_q && cfg_priv &&
               (cfg_secure || wm_new >= wm_q);

  wire p_sec_hit  = sec_en & psec_q[p_target] & ~p_secure;
  wire p_priv_hit = ppriv_q[p_target] & ~p_priv;
  wire p_block    = p_sec_hit | p_priv_hit;

  assign p_allow  = p_valid & ~p_block;
  assign p_wr_out = p_allow & p_write;
  assign p_rdata  = (p_allow && !p_write) ? p_rdata_in : 32'd0;

  wire m_block = sec_en & ~m_secure & ({1'b0, m_addr} < wm_q);
  assign m_allow = m_valid & ~m_block;

  logic [NPERIPH-1:0] p_set, p_clr;
  always_comb begin
    p_set = '0;
    if (p_valid && p_block && sec_en) p_set[p_target] = 1'b1;
    p_clr = (wr_trust && cfg_addr == 3'd5) ? cfg_wdata[NPERIPH-1:0] : '0;
  end
  wire m_set = m_valid & m_block;
  wire m_clr = wr_trust && cfg_addr == 3'd7 && cfg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q  <= 1'b0;
      psec_q  <= '0;
      ppriv_q <= '0;
      wm_q    <= '0;
      pie_q   <= '0;
      pflag_q <= '0;
      mie_q   <= 1'b0;
      mflag_q <= 1'b0;
    end else begin
      if (wr_trust && cfg_addr == 3'd0 && cfg_wdata[0]) lock_q <= 1'b1;
      if (wr_trust && !lock_q && cfg_addr == 3'd1) psec_q  <= cfg_wdata[NPERIPH-1:0];
      if (wr_trust && !lock_q && cfg_addr == 3'd2) ppriv_q <= cfg_wdata[NPERIPH-1:0];
      if (wm_ok) wm_q <= wm_new;
      if (wr_trust && cfg_addr == 3'd4) pie_q <= cfg_wdata[NPERIPH-1:0];
      if (wr_trust && cfg_addr == 3'd6) mie_q <= cfg_wdata[0];
      pflag_q <= (pflag_q & ~p_clr) | p_set;
      mflag_q <= (mflag_q & ~m_clr) | m_set;
    end
  end

  always_comb begin
    case (cfg_addr)
      3'd0:    cfg_rdata = {31'd0, lock_q};
      3'd1:    cfg_rdata = 32'(psec_q);
      3'd2:    cfg_rdata = 32'(ppriv_q);
      3'd3:    cfg_rdata = 32'(wm_q);
      3'd4:    cfg_rdata = 32'(pie_q);
      3'd5:    cfg_rdata = 32'(pflag_q);
      3'd6:    cfg_rdata = {31'd0, mie_q};
      default: cfg_rdata = {31'd0, mflag_q};
    endcase
  end

  assign irq = sec_en & ((|(pie_q & pflag_q)) | (mie_q & mflag_q));

endmodule

module sec_gate_chk #(
  parameter int NPERIPH = 32,
  parameter int TW      = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sec_en,
  input logic               p_valid,
  input logic [TW-1:0]      p_target,
  input logic               p_priv,
  input logic               p_write,
  input logic               p_allow,
  input logic               p_wr_out,
  input logic [31:0]        p_rdata,
  input logic               m_valid,
  input logic               m_allow,
  input logic               irq,
  input logic               lock_q,
  input logic [NPERIPH-1:0] psec_q,
  input logic [NPERIPH-1:0] ppriv_q,
  input logic [NPERIPH-1:0] pflag_q
);

  p_lock_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);

  p_locked_masks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> ($stable(psec_q) && $stable(ppriv_q)));

  p_priv_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (p_valid && !p_priv && ppriv_q[p_target]) |-> !p_allow);

  p_blocked_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (p_valid && !p_allow) |-> (!p_wr_out && p_rdata == 32'd0));

  p_write_no_rdata_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (p_valid && p_write) |-> p_rdata == 32'd0);

  p_mem_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !sec_en) |-> m_allow);

  p_flag_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (p_valid && sec_en && !p_allow) |=> pflag_q[$past(p_target)]);

  p_irq_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_en |-> !irq);

endmodule

bind sec_gate sec_gate_chk #(.NPERIPH(NPERIPH), .TW(TW)) u_chk (.*);

// File: tb/tb_sec_gate.sv
`timescale 1ns/1ps
module tb_sec_gate;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sec_en = 1'b1;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic cfg_secure = 1'b0, cfg_priv = 1'b0;
  logic [31:0] cfg_rdata;
  logic p_valid = 1'b0;
  logic [4:0] p_target = '0;
  logic p_secure = 1'b0, p_priv = 1'b0, p_write = 1'b0;
  logic [31:0] p_rdata_in = 32'hC0DE_0000;
  logic p_allow, p_wr_out;
  logic [31:0] p_rdata;
  logic m_valid = 1'b0;
  logic [11:0] m_addr = '0;
  logic m_secure = 1'b0;
  logic m_allow, irq;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sec_gate dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, input bit s, input bit p);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d; cfg_secure = s; cfg_priv = p;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    cfg_addr = a;
    #0.5;
    chk(cfg_rdata == exp, tag, cfg_rdata, exp);
  endtask

  localparam logic [31:0] PSEC  = 32'hA5A5_3C0F;
  localparam logic [31:0] PPRIV = 32'h0FF0_96C3;

  task automatic sweep(input bit en);
    for (int t = 0; t < 32; t++) begin
      for (int c = 0; c < 8; c++) begin
        bit s, p, w, blk;
        logic [31:0] exp_rd;
        s = c[0]; p = c[1]; w = c[2];
        blk = (en && PSEC[t] && !s) || (PPRIV[t] && !p);
        @(negedge clk);
        sec_en = en; p_valid = 1'b1; p_target = 5'(t);
        p_secure = s; p_priv = p; p_write = w;
        p_rdata_in = 32'hC0DE_0000 | 32'(t);
        #0.5;
        exp_rd = (!blk && !w) ? p_rdata_in : 32'd0;
        chk(p_allow == !blk, en ? "R5 allow" : "R6 allow", {31'd0, p_allow}, {31'd0, !blk});
        chk(p_wr_out == (!blk && w) && p_rdata == exp_rd, "R7 data gating",
            p_rdata, exp_rd);
      end
    end
    @(negedge clk);
    p_valid = 1'b0;
  endtask

  task automatic mem(input logic [11:0] a, input bit s, input bit en, input bit exp_allow);
    @(negedge clk);
    sec_en = en; m_valid = 1'b1; m_addr = a; m_secure = s;
    #0.5;
    chk(m_allow == exp_allow, "R8 memory", {31'd0, m_allow}, {31'd0, exp_allow});
    @(negedge clk);
    m_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < 8; a++) rd_chk(3'(a), 32'd0, "R1 reset word");
    chk(irq == 1'b0, "R1 irq", {31'd0, irq}, 32'd0);

    wr(3'd1, PSEC, 1'b0, 1'b1);
    rd_chk(3'd1, 32'd0, "R2 nonsecure write psec");
    wr(3'd1, PSEC, 1'b1, 1'b0);
    rd_chk(3'd1, 32'd0, "R2 unpriv write psec");
    wr(3'd1, PSEC, 1'b1, 1'b1);
    rd_chk(3'd1, PSEC, "R2 trusted write psec");
    wr(3'd2, PPRIV, 1'b0, 1'b0);
    rd_chk(3'd2, 32'd0, "R2 untrusted write ppriv");
    wr(3'd2, PPRIV, 1'b1, 1'b1);
    rd_chk(3'd2, PPRIV, "R2 trusted write ppriv");
    wr(3'd4, 32'hFFFF_FFFF, 1'b0, 1'b1);
    rd_chk(3'd4, 32'd0, "R2 nonsecure write enables");

    sweep(1'b0);
    rd_chk(3'd5, 32'd0, "R9 no flags when disabled");
    sweep(1'b1);
    rd_chk(3'd5, PSEC | PPRIV, "R9 flags after sweep");

    wr(3'd4, 32'h0000_0001, 1'b1, 1'b1);
    @(negedge clk); sec_en = 1'b1; #0.5;
    chk(irq == PSEC[0], "R10 irq enabled flag", {31'd0, irq}, {31'd0, PSEC[0]});
    sec_en = 1'b0; #0.5;
    chk(irq == 1'b0, "R10 irq off when disabled", {31'd0, irq}, 32'd0);
    sec_en = 1'b1;
    wr(3'd5, 32'h0000_0001, 1'b0, 1'b1);
    rd_chk(3'd5, PSEC | PPRIV, "R2 nonsecure clear ignored");
    wr(3'd5, 32'h0000_0001, 1'b1, 1'b1);
    rd_chk(3'd5, (PSEC | PPRIV) & ~32'd1, "R9 write one clears");
    chk(irq == 1'b0, "R10 irq after clear", {31'd0, irq}, 32'd0);

    wr(3'd3, 32'h100, 1'b1, 1'b1);
    rd_chk(3'd3, 32'h100, "R3 secure sets watermark");
    wr(3'd3, 32'h080, 1'b0, 1'b1);
    rd_chk(3'd3, 32'h100, "R3 nonsecure lower ignored");
    wr(3'd3, 32'h200, 1'b0, 1'b1);
    rd_chk(3'd3, 32'h200, "R3 nonsecure raise accepted");
    wr(3'd3, 32'h300, 1'b0, 1'b0);
    rd_chk(3'd3, 32'h200, "R3 unpriv ignored");
    wr(3'd3, 32'h180, 1'b1, 1'b1);
    rd_chk(3'd3, 32'h180, "R3 secure lowers");
    wr(3'd3, 32'h200, 1'b1, 1'b1);

    mem(12'h1FF, 1'b0, 1'b0, 1'b1);
    rd_chk(3'd7, 32'd0, "R9 memory no flag disabled");
    mem(12'h200, 1'b0, 1'b1, 1'b1);
    mem(12'h201, 1'b0, 1'b1, 1'b1);
    mem(12'h1FF, 1'b1, 1'b1, 1'b1);
    mem(12'h000, 1'b0, 1'b0, 1'b1);
    rd_chk(3'd7, 32'd0, "R9 memory flag clear");
    mem(12'h1FF, 1'b0, 1'b1, 1'b0);
    mem(12'h000, 1'b0, 1'b1, 1'b0);
    rd_chk(3'd7, 32'd1, "R9 memory flag set");
    wr(3'd4, 32'd0, 1'b1, 1'b1);
    wr(3'd6, 32'd1, 1'b1, 1'b1);
    @(negedge clk); #0.5;
    chk(irq == 1'b1, "R10 memory irq", {31'd0, irq}, 32'd1);
    wr(3'd7, 32'd1, 1'b1, 1'b1);
    @(negedge clk); #0.5;
    chk(irq == 1'b0, "R10 memory irq cleared", {31'd0, irq}, 32'd0);

    @(negedge clk);
    p_valid = 1'b1; p_target = 5'd0; p_secure = 1'b0; p_priv = 1'b0; p_write = 1'b0;
    cfg_we = 1'b1; cfg_addr = 3'd5; cfg_wdata = 32'd1; cfg_secure = 1'b1; cfg_priv = 1'b1;
    @(negedge clk);
    p_valid = 1'b0; cfg_we = 1'b0;
    rd_chk(3'd5, (PSEC | PPRIV), "R9 set wins over clear");

    wr(3'd0, 32'd1, 1'b0, 1'b1);
    rd_chk(3'd0, 32'd0, "R2 nonsecure lock ignored");
    wr(3'd0, 32'd1, 1'b1, 1'b1);
    rd_chk(3'd0, 32'd1, "R4 lock set");
    wr(3'd1, 32'd0, 1'b1, 1'b1);
    rd_chk(3'd1, PSEC, "R4 psec frozen");
    wr(3'd2, 32'd0, 1'b1, 1'b1);
    rd_chk(3'd2, PPRIV, "R4 ppriv frozen");
    wr(3'd3, 32'h300, 1'b1, 1'b1);
    rd_chk(3'd3, 32'h200, "R4 watermark frozen");
    wr(3'd0, 32'd0, 1'b1, 1'b1);
    rd_chk(3'd0, 32'd1, "R4 lock not clearable");
    wr(3'd4, 32'h8000_0000, 1'b1, 1'b1);
    rd_chk(3'd4, 32'h8000_0000, "R4 enables still writable");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule